// File: doc/BRIEF.md
# External Interrupt Grouping Controller

This block collects sixteen asynchronous external interrupt lines and presents them to a parent interrupt controller as three grouped request outputs. Each line is brought into the clock domain through a two-flop synchronizer and compared against a trigger condition chosen per pair of lines: a level (low or high) or an edge (rising, falling or either). A qualifying condition sets the line's pending bit.

Software drives a small word-addressed register bus. It programs the trigger fields, masks or unmasks lines, and acknowledges a serviced line by writing one to its pending bit. The pending bits that are not masked are ORed into three unequal groups: lines 0 to 3, lines 4 to 11 and lines 12 to 15. The group outputs are registered. A second write path sets the trigger of one line by its index and rejects indices out of range.

Top module: `ext_irq_grouper`

## Requirements
- R1: While reset is held, the trigger register reads 0, the mask register reads 0x0000FFFF (all lines masked), the pending register reads 0 and all three group outputs are 0.
- R2: A write to byte offset 0x0 loads the trigger register. Lines 2k and 2k+1 share the 3-bit field at bits 4k+2..4k, and bit 4k+3 always reads 0.
- R3: A write to offset 0x4 loads the mask from bits 15..0, where 1 masks a line. Bits 31..16 read 0.
- R4: A write to offset 0x8 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R5: Trigger codes 100 and 101 select the rising edge. A 0-to-1 change that is driven between clock edges shows in the pending register after the third rising clock edge. A 1-to-0 change sets nothing.
- R6: Trigger codes 010 and 011 select the falling edge. Only a 1-to-0 change sets the pending bit.
- R7: Trigger codes 110 and 111 select both edges. Either change sets the pending bit.
- R8: Code 000 is the active-low level and code 001 the active-high level. The pending bit is set on every cycle the active level persists, so an acknowledge only clears it once the level has gone away.
- R9: When an edge event and an acknowledge of the same line fall in the same cycle, the pending bit ends up set.
- R10: The group outputs are the ORs of (pending AND NOT mask) over lines 0-3, 4-11 and 12-15 respectively. They update on the same clock edge as the pending and mask registers.
- R11: A write to offset 0xC sets the trigger field of the line given in data bits 7..0 to the code in data bits 18..16. A line index above 15 leaves all registers unchanged. Reads of 0xC return 0.
- R12: A line's pending bit is set by its trigger condition whether or not the line is masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | External interrupt lines, asynchronous |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| grp_irq_o | output | 3 | Group requests: bit 0 lines 0-3, bit 1 lines 4-11, bit 2 lines 12-15 |

## Verification
The bench builds the block with its defaults: sixteen lines and group boundaries after lines 3 and 11. This small configuration allows a full sweep. All eight trigger codes are crossed with several steady-to-changed pin patterns, and every line is walked through masked and unmasked events. As a result, each pair-shared field, each group boundary and the level re-assertion after an acknowledge are all observed at the ports.

// File: rtl/eig_pkg.sv
package eig_pkg;

    localparam int FLD_W   = 3;
    localparam int NIB_W   = 4;

    localparam logic [3:0] OFF_TRIG = 4'h0;
    localparam logic [3:0] OFF_MASK = 4'h4;
    localparam logic [3:0] OFF_PEND = 4'h8;
    localparam logic [3:0] OFF_LINE = 4'hC;

    // Decode of a trigger field against current and previous sampled level.
    function automatic logic trig_hit(input logic [FLD_W-1:0] fld,
                                      input logic cur,
                                      input logic prv);
        logic r;
        case (fld[2:1])
            2'b00:   r = fld[0] ? cur : ~cur;
            2'b01:   r = prv & ~cur;
            2'b10:   r = ~prv & cur;
            default: r = prv ^ cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/eig_sync.sv
module eig_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/eig_detect.sv
module eig_detect #(
    parameter int N = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            cur_i,
    input  logic [(N/2)*eig_pkg::NIB_W-1:0] trig_i,
    output logic [N-1:0]            hit_o
);
    import eig_pkg::*;

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = cur_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        localparam int BASE = (i / 2) * NIB_W;
        assign hit_o[i] = trig_hit(trig_i[BASE +: FLD_W], cur_i[i], prev_q[i]);
    end
endmodule

// File: rtl/eig_regs.sv
module eig_regs #(
    parameter int N      = 16,
    parameter int A_LAST = 3,
    parameter int B_LAST = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wen_i,
    input  logic [3:0]              addr_i,
    input  logic [(N/2)*eig_pkg::NIB_W-1:0] wdata_i,
    input  logic [N-1:0]            hit_i,
    output logic [(N/2)*eig_pkg::NIB_W-1:0] rdata_o,
    output logic [2:0]              grp_o,
    output logic [N-1:0]            pend_o,
    output logic [N-1:0]            mask_o,
    output logic [(N/2)*eig_pkg::NIB_W-1:0] trig_o
);
    import eig_pkg::*;

    localparam int NFLD = N / 2;
    localparam int DW   = NFLD * NIB_W;
    localparam logic [DW-1:0] KEEP = {NFLD{4'b0111}};

    typedef struct packed {
        logic [DW-1:0] trig;
        logic [N-1:0]  mask;
        logic [N-1:0]  pend;
        logic [2:0]    grp;
    } regs_t;

    regs_t r_d, r_q;
    logic [N-1:0] ack;
    logic [N-1:0] live;
    logic [7:0]   idx;
    int           base;

    always_comb begin
        r_d  = r_q;
        ack  = '0;
        idx  = wdata_i[7:0];
        base = 32'(idx >> 1) * NIB_W;
        if (wen_i) begin
            case (addr_i)
                OFF_TRIG: r_d.trig = wdata_i & KEEP;
                OFF_MASK: r_d.mask = wdata_i[N-1:0];
                OFF_PEND: ack      = wdata_i[N-1:0];
                OFF_LINE: begin
                    if (idx <= 8'(N - 1))
                        r_d.trig[base +: FLD_W] = wdata_i[18:16];
                end
                default: ;
            endcase
        end
        r_d.pend   = (r_q.pend & ~ack) | hit_i;
        live       = r_d.pend & ~r_d.mask;
        r_d.grp[0] = |live[A_LAST:0];
        r_d.grp[1] = |live[B_LAST:A_LAST+1];
        r_d.grp[2] = |live[N-1:B_LAST+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.trig <= '0;
            r_q.mask <= '1;
            r_q.pend <= '0;
            r_q.grp  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr_i)
            OFF_TRIG: rdata_o = r_q.trig;
            OFF_MASK: rdata_o = DW'(r_q.mask);
            OFF_PEND: rdata_o = DW'(r_q.pend);
            default:  rdata_o = '0;
        endcase
    end

    assign grp_o  = r_q.grp;
    assign pend_o = r_q.pend;
    assign mask_o = r_q.mask;
    assign trig_o = r_q.trig;
endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper #(
    parameter int N_LINES = 16,
    parameter int A_LAST  = 3,
    parameter int B_LAST  = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] pin_i,
    input  logic        bus_wen,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [2:0]  grp_irq_o
);
    localparam int DW = (N_LINES / 2) * eig_pkg::NIB_W;

    logic [N_LINES-1:0] sync_w;
    logic [N_LINES-1:0] hit_w;
    logic [N_LINES-1:0] pend_w;
    logic [N_LINES-1:0] mask_w;
    logic [DW-1:0]      trig_w;

    eig_sync #(.W(N_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (sync_w)
    );

    eig_detect #(.N(N_LINES)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (sync_w),
        .trig_i (trig_w),
        .hit_o  (hit_w)
    );

    eig_regs #(.N(N_LINES), .A_LAST(A_LAST), .B_LAST(B_LAST)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wen_i   (bus_wen),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .hit_i   (hit_w),
        .rdata_o (bus_rdata),
        .grp_o   (grp_irq_o),
        .pend_o  (pend_w),
        .mask_o  (mask_w),
        .trig_o  (trig_w)
    );
endmodule

// File: rtl/eig_checker.sv
module eig_checker #(
    parameter int N      = 16,
    parameter int A_LAST = 3,
    parameter int B_LAST = 11
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wen,
    input logic [3:0]              bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [N-1:0]            hit,
    input logic [N-1:0]            pend,
    input logic [N-1:0]            mask,
    input logic [(N/2)*4-1:0]      trig,
    input logic [2:0]              grp
);
    a_r12_hit_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == 4'h8)
        |=> ((pend & $past(bus_wdata[N-1:0]) & ~$past(hit)) == '0));

    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(hit)) == '0));

    a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == 4'h4) |=> (mask == $past(bus_wdata[N-1:0])));

    a_r11_reject_index: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == 4'hC && bus_wdata[7:0] > 8'(N - 1))
        |=> ($stable(trig) && $stable(mask)));

    a_r10_group_low: assert property (@(posedge clk) disable iff (!rst_n)
        grp[0] == |(pend[A_LAST:0] & ~mask[A_LAST:0]));

    a_r10_group_mid: assert property (@(posedge clk) disable iff (!rst_n)
        grp[1] == |(pend[B_LAST:A_LAST+1] & ~mask[B_LAST:A_LAST+1]));

    a_r10_group_high: assert property (@(posedge clk) disable iff (!rst_n)
        grp[2] == |(pend[N-1:B_LAST+1] & ~mask[N-1:B_LAST+1]));
endmodule

bind ext_irq_grouper eig_checker #(
    .N(N_LINES), .A_LAST(A_LAST), .B_LAST(B_LAST)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hit       (hit_w),
    .pend      (pend_w),
    .mask      (mask_w),
    .trig      (trig_w),
    .grp       (grp_irq_o)
);

// File: tb/test_ext_irq_grouper.sv
module test_ext_irq_grouper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_i = 16'h0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [2:0]  grp_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ext_irq_grouper i_ext_irq_grouper (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .grp_irq_o(grp_irq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic lvl(input int c, input logic b);
        return (c == 0 && !b) || (c == 1 && b);
    endfunction

    function automatic logic evt(input int c, input logic a, input logic b);
        case (c / 2)
            1:       return a && !b;
            2:       return !a && b;
            3:       return a != b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [2:0] grp_of(input int i);
        if (i <= 3) return 3'b001;
        if (i <= 11) return 3'b010;
        return 3'b100;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [15:0] pa [3];
        logic [15:0] pt [3];
        pa[0] = 16'h0000; pa[1] = 16'hFFFF; pa[2] = 16'hA5C3;
        pt[0] = 16'hFFFF; pt[1] = 16'h0F0F; pt[2] = 16'h3C96;

        // R1 reset state
        repeat (3) @(posedge clk);
        rd(4'h0, d); check("R1 trig", d, 32'h0);
        rd(4'h4, d); check("R1 mask", d, 32'h0000FFFF);
        rd(4'h8, d); check("R1 pend", d, 32'h0);
        check("R1 grp", {29'h0, grp_irq_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2 field layout / unused bits
        wr(4'h0, 32'hFFFFFFFF); rd(4'h0, d); check("R2 unused bits", d, 32'h77777777);
        wr(4'h0, 32'h12345670); rd(4'h0, d); check("R2 load", d, 32'h12345670);
        // R3 mask
        wr(4'h4, 32'hFFFF1234); rd(4'h4, d); check("R3 mask", d, 32'h00001234);
        // R11 per-line write
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h00030005); rd(4'h0, d); check("R11 line5", d, 32'h00000300);
        wr(4'hC, 32'h0006000F); rd(4'h0, d); check("R11 line15", d, 32'h60000300);
        wr(4'hC, 32'h00070010); rd(4'h0, d); check("R11 idx16 rejected", d, 32'h60000300);
        wr(4'hC, 32'h000700FF); rd(4'h0, d); check("R11 idx255 rejected", d, 32'h60000300);
        rd(4'h4, d); check("R11 mask untouched", d, 32'h00001234);
        rd(4'hC, d); check("R11 read zero", d, 32'h0);

        // R5..R8 sweep over all codes and pin patterns
        for (int c = 0; c < 8; c++) begin
            wr(4'h0, {8{1'b0, 3'(c)}});
            for (int a = 0; a < 3; a++) begin
                for (int t = 0; t < 3; t++) begin
                    logic [15:0] pa_v, pb_v, e0, e1;
                    pa_v = pa[a]; pb_v = pa[a] ^ pt[t];
                    @(negedge clk); pin_i = pa_v;
                    repeat (5) @(posedge clk);
                    wr(4'h8, 32'h0000FFFF);
                    for (int i = 0; i < 16; i++) e0[i] = lvl(c, pa_v[i]);
                    rd(4'h8, d);
                    check("R8 ack under level", d, {16'h0, e0});
                    @(negedge clk); pin_i = pb_v;
                    repeat (4) @(posedge clk);
                    for (int i = 0; i < 16; i++)
                        e1[i] = e0[i] | lvl(c, pb_v[i]) | evt(c, pa_v[i], pb_v[i]);
                    rd(4'h8, d);
                    if (c >= 4) check("R5 rising", d, {16'h0, e1});
                    else if (c >= 2) check("R6 falling / R7", d, {16'h0, e1});
                    else check("R8 level", d, {16'h0, e1});
                end
            end
        end
        // R7 both edges explicit on code 110
        wr(4'h0, 32'h66666666);
        @(negedge clk); pin_i = 16'h0; repeat (5) @(posedge clk);
        wr(4'h8, 32'hFFFF);
        @(negedge clk); pin_i = 16'h00F0; repeat (4) @(posedge clk);
        wr(4'h8, 32'h00F0);
        @(negedge clk); pin_i = 16'h0; repeat (4) @(posedge clk);
        rd(4'h8, d); check("R7 both edges fall", d, 32'h00F0);

        // R8 level high released then acked
        wr(4'h0, 32'h11111111);
        @(negedge clk); pin_i = 16'h0001; repeat (4) @(posedge clk);
        wr(4'h8, 32'hFFFF); rd(4'h8, d); check("R8 held level", d, 32'h1);
        @(negedge clk); pin_i = 16'h0; repeat (4) @(posedge clk);
        wr(4'h8, 32'hFFFF); rd(4'h8, d); check("R8 released level", d, 32'h0);

        // R9 event and ack in the same cycle; R4 write-zero
        wr(4'h0, 32'h44444444);
        @(negedge clk); pin_i = 16'h0; repeat (5) @(posedge clk);
        wr(4'h8, 32'hFFFF);
        @(negedge clk); pin_i = 16'h0001;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_wen = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h1;
        @(negedge clk); bus_wen = 1'b0;
        rd(4'h8, d); check("R9 event wins", d, 32'h1);
        wr(4'h8, 32'h0); rd(4'h8, d); check("R4 write zero", d, 32'h1);
        wr(4'h8, 32'h1); rd(4'h8, d); check("R4 write one", d, 32'h0);
        @(negedge clk); pin_i = 16'h0; repeat (4) @(posedge clk);

        // R10 / R12 walk every line
        wr(4'h4, 32'h0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); pin_i = 16'(1 << i);
            repeat (4) @(posedge clk);
            @(negedge clk); check("R10 group", {29'h0, grp_irq_o}, {29'h0, grp_of(i)});
            rd(4'h8, d); check("R5 single line", d, 32'(1 << i));
            wr(4'h8, 32'hFFFF);
            @(negedge clk); pin_i = 16'h0;
            repeat (4) @(posedge clk);
            @(negedge clk); check("R5 no fall event", {29'h0, grp_irq_o}, 32'h0);
            wr(4'h4, 32'(1 << i));
            @(negedge clk); pin_i = 16'(1 << i);
            repeat (4) @(posedge clk);
            rd(4'h8, d); check("R12 masked pends", d, 32'(1 << i));
            check("R10 masked quiet", {29'h0, grp_irq_o}, 32'h0);
            wr(4'h4, 32'h0);
            check("R10 unmask", {29'h0, grp_irq_o}, {29'h0, grp_of(i)});
            wr(4'h8, 32'hFFFF);
            @(negedge clk); pin_i = 16'h0;
            repeat (4) @(posedge clk);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule